// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master together with the instant at which the data line may change. A protocol engine supplies a packed 32-bit timing word and a digital filter length. The block drives SCL low or releases it through an open-drain style control output. It also issues a one-cycle strobe once the data hold time has passed after SCL falls, and a free-running tick that divides the kernel clock by the prescaler. The SCL and SDA lines are brought back through two-flop synchronisers. A high phase only begins counting once the synchronised SCL is seen high, so a slave that keeps SCL low stretches the clock.

Configuration is captured on every cycle while the enable input is low and is frozen while it is high. Raising the enable starts with an SCL low phase that uses the captured values. Dropping the enable returns the block to the released idle state on the next cycle.

Every period is measured in kernel clock cycles. P is the prescaler field plus one. F is the filter length, saturated at the filter maximum.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_low_o`, `sda_strobe_o` and `tick_o` are 0, and both synchronised outputs are 1. The timing word fields are decoded as follows: prescaler in bits 31:28, setup count in bits 23:20, hold count in bits 19:16, high count in bits 15:8 and low count in bits 7:0.
- R2: While enabled, `tick_o` pulses for one cycle every P cycles, and the first pulse comes P cycles after the enable is sampled. While disabled, it stays 0.
- R3: SCL is held low for max((low+1)·P + 2 + F, hold_time + setup_time) cycles.
- R4: Once the synchronised SCL is first seen high, SCL stays released for (high+1)·P + 2 + F further cycles before it is driven low again.
- R5: `sda_strobe_o` pulses exactly once per low phase, hold·P + 1 cycles after SCL was first driven low.
- R6: SCL is not released until setup_time = (setup+1)·P cycles have elapsed after the strobe.
- R7: If SCL is held low externally after release, the high count does not start until the synchronised line reads high.
- R8: The timing word and filter length are captured only while the enable is low, and changes made while enabled have no effect. A filter length above the maximum (16) acts as the maximum.
- R9: `scl_sync_o` and `sda_sync_o` reproduce `scl_in` and `sda_in` two cycles later.
- R10: When the enable is sampled low, SCL is released and the strobe is cleared on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; configuration is loaded while low |
| timing_word | input | 32 | Packed prescaler, setup, hold, high and low counts |
| filt_len | input | 5 | Digital filter length in kernel clocks |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| tick_o | output | 1 | Prescaled timing tick |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_strobe_o | output | 1 | One-cycle pulse: SDA may change now |
| scl_sync_o | output | 1 | Synchronised SCL |
| sda_sync_o | output | 1 | Synchronised SDA |

## Verification
The assertions assume that the bus inputs come from an open-drain line. While the block drives SCL low, the sensed SCL is low too, and during a high phase nothing else pulls SCL low once it has been seen high. They also assume that the enable is a level held for many cycles, not a glitch. The stimulus loops `scl_in` back from `scl_low_o` and adds a stretch input. That input is raised only during a low phase and dropped before the following high count begins. Configuration changes are made both while disabled and while enabled, and the filter length is also driven past its maximum.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

  localparam int PRE_W = 4;   // prescaler field width
  localparam int DLY_W = 4;   // setup / hold field width
  localparam int LEN_W = 8;   // high / low field width
  localparam int FLT_W = 8;   // internal filter length width

  // bit positions inside the timing word
  localparam int PRE_LSB = 28;
  localparam int SU_LSB  = 20;
  localparam int HD_LSB  = 16;
  localparam int HI_LSB  = 8;
  localparam int LO_LSB  = 0;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [DLY_W-1:0] setup;
    logic [DLY_W-1:0] hold;
    logic [LEN_W-1:0] hi_cnt;
    logic [LEN_W-1:0] lo_cnt;
    logic [FLT_W-1:0] filt;
  } tcfg_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_t;

  function automatic tcfg_t unpack_cfg(input logic [31:0] w,
                                       input logic [FLT_W-1:0] f,
                                       input logic [FLT_W-1:0] fmax);
    tcfg_t c;
    c.presc  = w[PRE_LSB +: PRE_W];
    c.setup  = w[SU_LSB  +: DLY_W];
    c.hold   = w[HD_LSB  +: DLY_W];
    c.hi_cnt = w[HI_LSB  +: LEN_W];
    c.lo_cnt = w[LO_LSB  +: LEN_W];
    c.filt   = (f > fmax) ? fmax : f;
    return c;
  endfunction

endpackage

// File: rtl/scl_tgen_sync.sv
module scl_tgen_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/scl_tgen_prescaler.sv
module scl_tgen_prescaler #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] div,
  output logic          tick_o
);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      tick_o <= 1'b0;
    end else if (!run) begin
      pc     <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (pc == div);
      pc     <= (pc == div) ? '0 : pc + 1'b1;
    end
  end

endmodule

// File: rtl/scl_tgen_phase.sv
module scl_tgen_phase
  import scl_tgen_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  tcfg_t cfg,
  input  logic  scl_hi,
  output logic  scl_low_o,
  output logic  sda_strobe_o
);

  phase_t           st;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [CNT_W-1:0] pdiv, lo_len, hi_len, hold_len, setup_len, hs_len, rel_len;

  // period arithmetic, all in kernel clocks
  always_comb begin
    pdiv      = CNT_W'(cfg.presc) + CNT_W'(1);
    lo_len    = (CNT_W'(cfg.lo_cnt) + CNT_W'(1)) * pdiv + CNT_W'(2) + CNT_W'(cfg.filt);
    hi_len    = (CNT_W'(cfg.hi_cnt) + CNT_W'(1)) * pdiv + CNT_W'(2) + CNT_W'(cfg.filt);
    hold_len  = CNT_W'(cfg.hold) * pdiv + CNT_W'(1);
    setup_len = (CNT_W'(cfg.setup) + CNT_W'(1)) * pdiv;
    hs_len    = hold_len + setup_len;
    rel_len   = (lo_len > hs_len) ? lo_len : hs_len;
    cnt_nx    = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st           <= PH_IDLE;
      cnt          <= '0;
      scl_low_o    <= 1'b0;
      sda_strobe_o <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: begin
          st           <= PH_LOW;
          cnt          <= '0;
          scl_low_o    <= 1'b1;
          sda_strobe_o <= 1'b0;
        end
        PH_LOW: begin
          sda_strobe_o <= (cnt_nx == hold_len);
          if (cnt_nx == rel_len) begin
            st        <= PH_WAIT;
            cnt       <= '0;
            scl_low_o <= 1'b0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        PH_WAIT: begin
          sda_strobe_o <= 1'b0;
          if (scl_hi) begin
            st  <= PH_HIGH;
            cnt <= CNT_W'(1);
          end
        end
        default: begin
          sda_strobe_o <= 1'b0;
          if (cnt_nx == hi_len) begin
            st        <= PH_LOW;
            cnt       <= '0;
            scl_low_o <= 1'b1;
          end else begin
            cnt <= cnt_nx;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int FILT_MAX = 16,
  parameter int SYNC_STAGES = 2,
  localparam int FILT_W = $clog2(FILT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [31:0]       timing_word,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              tick_o,
  output logic              scl_low_o,
  output logic              sda_strobe_o,
  output logic              scl_sync_o,
  output logic              sda_sync_o
);

  localparam int MAX_LEN = (2**LEN_W) * (2**PRE_W) + 2 + FILT_MAX;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  tcfg_t      cfg;
  logic [1:0] synced;

  always_ff @(posedge clk) begin
    if (rst)          cfg <= '0;
    else if (!enable) cfg <= unpack_cfg(timing_word, FLT_W'(filt_len), FLT_W'(FILT_MAX));
  end

  scl_tgen_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sda_in, scl_in}),
    .q   (synced)
  );

  assign scl_sync_o = synced[0];
  assign sda_sync_o = synced[1];

  scl_tgen_prescaler #(.PW(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (enable),
    .div    (cfg.presc),
    .tick_o (tick_o)
  );

  scl_tgen_phase #(.CNT_W(CNT_W)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .run          (enable),
    .cfg          (cfg),
    .scl_hi       (synced[0]),
    .scl_low_o    (scl_low_o),
    .sda_strobe_o (sda_strobe_o)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_in,
  input logic tick_o,
  input logic scl_low_o,
  input logic sda_strobe_o,
  input logic scl_sync_o
);

  logic [1:0] age_q;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)               seen_q <= 1'b0;
    else if (sda_strobe_o) seen_q <= 1'b1;
    else if (!scl_low_o)   seen_q <= 1'b0;
  end

  p_tick_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick_o);

  p_strobe_in_low_r5: assert property (@(posedge clk) disable iff (rst)
    sda_strobe_o |-> scl_low_o);

  p_strobe_once_r5: assert property (@(posedge clk) disable iff (rst)
    sda_strobe_o |=> !sda_strobe_o);

  p_setup_before_release_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_low_o) && $past(enable)) |-> seen_q);

  p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_low_o && !sda_strobe_o));

  p_sync_delay_r9: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> (scl_sync_o == $past(scl_in, 2)));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .scl_in       (scl_in),
  .tick_o       (tick_o),
  .scl_low_o    (scl_low_o),
  .sda_strobe_o (sda_strobe_o),
  .scl_sync_o   (scl_sync_o)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] timing_word = '0;
  logic [4:0]  filt_len = '0;
  logic        sda_in = 1'b1;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        tick_o, scl_low_o, sda_strobe_o, scl_sync_o, sda_sync_o;

  always #5 clk = ~clk;

  assign scl_in = !scl_low_o && !stretch;

  scl_timing_gen uut (
    .clk (clk), .rst (rst), .enable (enable), .timing_word (timing_word),
    .filt_len (filt_len), .scl_in (scl_in), .sda_in (sda_in),
    .tick_o (tick_o), .scl_low_o (scl_low_o), .sda_strobe_o (sda_strobe_o),
    .scl_sync_o (scl_sync_o), .sda_sync_o (sda_sync_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mP, mSU, mHD, mH, mL, mF;
  int m_ph, m_k, m_pc;
  bit m_low, m_stb, m_tick, m_s1, m_s2, m_d1, m_d2;
  int run_len, last_low, last_high, max_high;
  bit prev_low;

  function automatic int lo_t();  return (mL + 1) * (mP + 1) + 2 + mF; endfunction
  function automatic int hi_t();  return (mH + 1) * (mP + 1) + 2 + mF; endfunction
  function automatic int hd_t();  return mHD * (mP + 1) + 1; endfunction
  function automatic int rel_t();
    int su = (mSU + 1) * (mP + 1);
    return (lo_t() > hd_t() + su) ? lo_t() : hd_t() + su;
  endfunction

  always @(posedge clk) begin
    bit line, n_s1, n_s2, n_d1, n_d2;
    if (rst) begin
      mP = 0; mSU = 0; mHD = 0; mH = 0; mL = 0; mF = 0;
      m_ph = 0; m_k = 0; m_pc = 0;
      m_low = 0; m_stb = 0; m_tick = 0;
      m_s1 = 1; m_s2 = 1; m_d1 = 1; m_d2 = 1;
    end else begin
      line = !m_low && !stretch;
      n_s1 = line; n_s2 = m_s1; n_d1 = sda_in; n_d2 = m_d1;
      m_tick = enable && (m_pc == mP);
      m_pc = !enable ? 0 : ((m_pc == mP) ? 0 : m_pc + 1);
      if (!enable) begin
        m_ph = 0; m_k = 0; m_low = 0; m_stb = 0;
        mP = timing_word[31:28]; mSU = timing_word[23:20]; mHD = timing_word[19:16];
        mH = timing_word[15:8];  mL = timing_word[7:0];
        mF = (filt_len > 16) ? 16 : filt_len;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_k = 0; m_low = 1; m_stb = 0; end
          1: begin
            m_stb = (m_k + 1 == hd_t());
            if (m_k + 1 == rel_t()) begin m_ph = 2; m_k = 0; m_low = 0; end
            else m_k++;
          end
          2: begin m_stb = 0; if (m_s2) begin m_ph = 3; m_k = 1; end end
          default: begin
            m_stb = 0;
            if (m_k + 1 == hi_t()) begin m_ph = 1; m_k = 0; m_low = 1; end
            else m_k++;
          end
        endcase
      end
      m_s1 = n_s1; m_s2 = n_s2; m_d1 = n_d1; m_d2 = n_d2;
    end
    #2;
    if (!rst && !done) begin
      chk(scl_low_o == m_low, "R3 R4 R6 R7 scl_low_o", scl_low_o, m_low);
      chk(sda_strobe_o == m_stb, "R5 sda_strobe_o", sda_strobe_o, m_stb);
      chk(tick_o == m_tick, "R2 tick_o", tick_o, m_tick);
      chk(scl_sync_o == m_s2 && sda_sync_o == m_d2, "R9 sync outputs",
          {scl_sync_o, sda_sync_o}, {m_s2, m_d2});
      if (enable) begin
        if (scl_low_o == prev_low) run_len++;
        else begin
          if (prev_low) last_low = run_len;
          else begin
            last_high = run_len;
            if (run_len > max_high) max_high = run_len;
          end
          run_len = 1;
        end
        prev_low = scl_low_o;
      end else begin
        run_len = 0; prev_low = 0;
      end
    end
  end

  int cyc = 0;
  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      sda_in = cyc[1] ^ cyc[3];
    end
  endtask

  task automatic set_cfg(input int p, input int su, input int hd, input int h, input int l, input int f);
    timing_word = {p[3:0], 4'h0, su[3:0], hd[3:0], h[7:0], l[7:0]};
    filt_len = f[4:0];
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    run(4);
    rst = 1'b0;
    run(1);
    // R1: reset state
    chk(!scl_low_o && !sda_strobe_o && !tick_o, "R1 reset outputs",
        {scl_low_o, sda_strobe_o, tick_o}, 0);
    chk(scl_sync_o && sda_sync_o, "R1 reset sync", {scl_sync_o, sda_sync_o}, 3);

    // cfg A: low 12, hold 5, setup 4, high 10 (+2 sync latency)
    set_cfg(1, 1, 2, 3, 4, 0);
    run(2);
    enable = 1'b1;
    run(100);
    chk(last_low == 12, "R1 R3 low length", last_low, 12);
    chk(last_high == 12, "R4 high length", last_high, 12);

    // R8: change while enabled is ignored
    set_cfg(0, 5, 3, 1, 0, 0);
    run(60);
    chk(last_low == 12, "R8 low length after live change", last_low, 12);
    chk(last_high == 12, "R8 high length after live change", last_high, 12);

    // R7: stretch during a low phase
    max_high = 0;
    while (!scl_low_o) run(1);
    stretch = 1'b1;
    run(40);
    stretch = 1'b0;
    run(60);
    chk(max_high > 12, "R7 stretched high", max_high, 13);

    // R10: disable mid phase
    while (!scl_low_o) run(1);
    run(3);
    enable = 1'b0;
    @(posedge clk); #2;
    chk(!scl_low_o && !sda_strobe_o, "R10 release on disable", scl_low_o, 0);
    run(3);
    chk(!tick_o, "R2 tick quiet when disabled", tick_o, 0);

    // cfg B: setup dominated, low = 4 + 6 = 10, high = 4 + 2
    set_cfg(0, 5, 3, 1, 0, 0);
    run(2);
    enable = 1'b1;
    run(80);
    chk(last_low == 10, "R6 setup dominated low", last_low, 10);
    chk(last_high == 6, "R4 short high", last_high, 6);
    enable = 1'b0;

    // cfg C: filter length 20 clamps to 16
    set_cfg(3, 0, 0, 2, 2, 20);
    run(2);
    enable = 1'b1;
    run(200);
    chk(last_low == 30, "R8 clamped filter low", last_low, 30);
    chk(last_high == 32, "R8 clamped filter high", last_high, 32);
    enable = 1'b0;
    run(4);
    finish_up();
  end

endmodule